// File: doc/BRIEF.md
# Dual-Converter Parallel Bus Interface

This block is the digital control logic between an 8-bit microprocessor bus and a converter front end made of one two-channel ADC and two DACs. The processor talks to it through an active-low chip select, a converter-type select (ADC or DAC), a channel select (A or B) and active-low write and read strobes. A write aimed at the ADC starts a conversion on the chosen channel. A write aimed at the DACs loads one of two DAC holding registers. A read puts the latest conversion result on the bus. An active-low interrupt line tells the processor when a conversion has finished.

The analog conversion is stood in for by a busy timer of `BUSY_CYCLES` clocks and two result input ports, one for each channel. The timer's busy flag and channel go out to the front end. All bus control lines are brought into the system clock through two-flop synchronizers, and strobe edges are taken from the synchronized values. The data bus is split into a data-out port and an output-enable port. A DAC write normally takes the bus data. If the read strobe is held low during the write, it takes the stored conversion result instead.

Top module: `dcbus_ctrl`

## Requirements
- R1: After reset the interrupt output is high, the bus output enable is low, both DAC registers and the result register are zero, and the converter is not busy.
- R2: A write-strobe falling edge while chip select is low and converter select is 0 (ADC) starts a conversion. Channel select 0 picks channel A and 1 picks channel B. At the end of the conversion, the result register takes that channel's result input.
- R3: The write-strobe falling edge that starts a conversion drives the interrupt output high.
- R4: A conversion keeps `conv_busy` high for exactly `BUSY_CYCLES` clocks. The interrupt output goes low when the conversion completes, and at no other time.
- R5: A read-strobe falling edge while chip select is low and no conversion is running drives the interrupt output high. A read strobe held low does not clear the interrupt flag when a conversion completes under it.
- R6: While the synchronized chip select and read strobe are both low, the bus output enable is high and the data-out port carries the result register. Otherwise the enable is low.
- R7: A write-strobe falling edge with chip select low, converter select 1 (DAC) and read strobe high loads the bus data into DAC A when channel select is 0, or into DAC B when it is 1. The other DAC keeps its value.
- R8: The same DAC write with the read strobe low loads the result register into the selected DAC. The bus data is ignored.
- R9: While chip select is high, strobe edges start nothing, load nothing and leave the interrupt unchanged, and the bus output enable stays low.
- R10: A DAC write leaves the interrupt output unchanged.
- R11: The result register changes only when a conversion ends. A start during a running conversion restarts the timer with the new channel, so the busy time becomes the gap between the starts plus `BUSY_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sel_dac | input | 1 | Converter select: 0 ADC, 1 DAC |
| ch_b | input | 1 | Channel select: 0 A, 1 B |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | DW | Data from the processor bus |
| adc_res_a | input | DW | Conversion result of channel A |
| adc_res_b | input | DW | Conversion result of channel B |
| bus_out | output | DW | Data to the processor bus |
| bus_oe | output | 1 | Bus output enable; low means high impedance |
| irq_n | output | 1 | Conversion-done interrupt, active low |
| dac_a | output | DW | DAC A holding register |
| dac_b | output | DW | DAC B holding register |
| conv_busy | output | 1 | Conversion timer running |
| conv_ch | output | 1 | Channel of the current or last conversion |

## Verification
The assertions assume that the processor never lets a write-strobe edge and a read-strobe edge reach the synchronized domain in the same clock. They also assume that every strobe level, including each gap between strobes, lasts at least two clocks, so that no edge is lost in the synchronizers. The stimulus changes inputs only on falling clock edges and holds every level for two or more clocks. It keeps select lines and bus data steady around each strobe edge, and it never moves both strobes at once. The interrupt-hold check after a DAC write is qualified on the absence of a completion or read-clear event in the same cycle.

// File: rtl/dcbus_pkg.sv
package dcbus_pkg;

  // synchronized bus control lines
  typedef struct packed {
    logic cs_n;
    logic sel_dac;
    logic ch_b;
    logic wr_n;
    logic rd_n;
  } ctl_t;

  localparam int CTL_W = 5;
  // idle bus: not selected, ADC, channel A, strobes high
  localparam logic [CTL_W-1:0] CTL_IDLE = 5'b10011;

  function automatic logic conv_start(ctl_t c, logic wr_fall);
    return !c.cs_n && !c.sel_dac && wr_fall;
  endfunction

  function automatic logic dac_load(ctl_t c, logic wr_fall);
    return !c.cs_n && c.sel_dac && wr_fall;
  endfunction

  function automatic logic bus_drive(ctl_t c);
    return !c.cs_n && !c.rd_n;
  endfunction

  function automatic logic dac_from_result(ctl_t c);
    return !c.rd_n;
  endfunction

  function automatic logic read_clear(ctl_t c, logic rd_fall, logic busy);
    return !c.cs_n && rd_fall && !busy;
  endfunction

  // interrupt next state: start wins, then completion, then read clear
  function automatic logic irq_next(logic cur, logic start, logic done, logic clr);
    if (start)     return 1'b1;
    else if (done) return 1'b0;
    else if (clr)  return 1'b1;
    else           return cur;
  endfunction

endpackage

// File: rtl/dcbus_sync.sv
module dcbus_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dcbus_conv_timer.sv
module dcbus_conv_timer #(
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_ch,
  input  logic [DW-1:0] res_a,
  input  logic [DW-1:0] res_b,
  output logic          busy,
  output logic          done,
  output logic          ch,
  output logic [DW-1:0] result
);

  localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  // completion: last busy cycle, unless a new start takes over
  assign done = busy && (cnt == '0) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ch   <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
      ch   <= start_ch;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result <= '0;
    else if (done) result <= ch ? res_b : res_a;
  end

endmodule

// File: rtl/dcbus_dac_regs.sv
module dcbus_dac_regs #(
  parameter int DW     = 8,
  parameter int N_DACS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic          use_result,
  input  logic [DW-1:0] bus_data,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b
);

  logic [DW-1:0] regs [N_DACS];
  logic [DW-1:0] src;

  assign src = use_result ? result : bus_data;

  for (genvar g = 0; g < N_DACS; g++) begin : g_dac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (we && (32'(sel) == g))     regs[g] <= src;
    end
  end

  assign dac_a = regs[0];
  assign dac_b = regs[1];

endmodule

// File: rtl/dcbus_ctrl.sv
module dcbus_ctrl
  import dcbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sel_dac,
  input  logic          ch_b,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] adc_res_a,
  input  logic [DW-1:0] adc_res_b,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          irq_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic          conv_busy,
  output logic          conv_ch
);

  localparam int SW = CTL_W + DW;
  localparam logic [SW-1:0] SYNC_RST = {CTL_IDLE, {DW{1'b0}}};

  // synchronized control and data (data kept aligned with the strobes)
  logic [SW-1:0] sync_d, sync_q;
  ctl_t          ctl_s;
  logic [DW-1:0] din_s;

  assign sync_d = {cs_n, sel_dac, ch_b, wr_n, rd_n, bus_in};

  dcbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sync_d),
    .q    (sync_q)
  );

  assign ctl_s = ctl_t'(sync_q[SW-1:DW]);
  assign din_s = sync_q[DW-1:0];

  // strobe edge detection
  logic wr_prev, rd_prev, wr_fall, rd_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b1;
      rd_prev <= 1'b1;
    end else begin
      wr_prev <= ctl_s.wr_n;
      rd_prev <= ctl_s.rd_n;
    end
  end

  assign wr_fall = wr_prev && !ctl_s.wr_n;
  assign rd_fall = rd_prev && !ctl_s.rd_n;

  // named internal events
  logic          start_evt, done_evt, rd_clr_evt, dac_we, cs_s;
  logic [DW-1:0] result_q;

  assign cs_s       = !ctl_s.cs_n;
  assign start_evt  = conv_start(ctl_s, wr_fall);
  assign dac_we     = dac_load(ctl_s, wr_fall);
  assign rd_clr_evt = read_clear(ctl_s, rd_fall, conv_busy);

  dcbus_conv_timer #(.DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .start_ch(ctl_s.ch_b),
    .res_a   (adc_res_a),
    .res_b   (adc_res_b),
    .busy    (conv_busy),
    .done    (done_evt),
    .ch      (conv_ch),
    .result  (result_q)
  );

  dcbus_dac_regs #(.DW(DW), .N_DACS(2)) u_dacs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (dac_we),
    .sel       (ctl_s.ch_b),
    .use_result(dac_from_result(ctl_s)),
    .bus_data  (din_s),
    .result    (result_q),
    .dac_a     (dac_a),
    .dac_b     (dac_b)
  );

  // interrupt flag, active low
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= !irq_next(!irq_q, start_evt, done_evt, rd_clr_evt);
  end

  assign irq_n = !irq_q;

  // bus drive
  assign bus_oe  = bus_drive(ctl_s);
  assign bus_out = bus_oe ? result_q : '0;

endmodule

// File: rtl/dcbus_ctrl_chk.sv
module dcbus_ctrl_chk #(
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_evt,
  input logic          done_evt,
  input logic          rd_clr_evt,
  input logic          dac_we,
  input logic          conv_busy,
  input logic          irq_n,
  input logic [DW-1:0] result_q
);

  // cycles since the latest start while busy
  int unsigned chk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_cnt <= 0;
    else if (start_evt)  chk_cnt <= 0;
    else if (conv_busy)  chk_cnt <= chk_cnt + 1;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> conv_busy);

  p_start_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> irq_n);

  p_done_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !irq_n);

  p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(done_evt));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy) |-> (chk_cnt == BUSY_CYCLES));

  p_rd_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !rd_clr_evt);

  p_dac_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_we && !done_evt && !rd_clr_evt && !start_evt) |=> $stable(irq_n));

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(result_q));

endmodule

bind dcbus_ctrl dcbus_ctrl_chk #(.DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .rd_clr_evt(rd_clr_evt),
  .dac_we    (dac_we),
  .conv_busy (conv_busy),
  .irq_n     (irq_n),
  .result_q  (result_q)
);

// File: tb/dcbus_ctrl_bench.sv
module dcbus_ctrl_bench;

  localparam int DW = 8;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, sel_dac = 1'b0, ch_b = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] bus_in = '0, adc_res_a = 8'h3C, adc_res_b = 8'hC5;
  logic [DW-1:0] bus_out, dac_a, dac_b;
  logic          bus_oe, irq_n, conv_busy, conv_ch;

  int checks = 0;
  int failures = 0;
  int busy_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dcbus_ctrl #(.DW(DW), .BUSY_CYCLES(N), .SYNC_STAGES(2)) u_dcbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_dac(sel_dac), .ch_b(ch_b),
    .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in), .adc_res_a(adc_res_a),
    .adc_res_b(adc_res_b), .bus_out(bus_out), .bus_oe(bus_oe), .irq_n(irq_n),
    .dac_a(dac_a), .dac_b(dac_b), .conv_busy(conv_busy), .conv_ch(conv_ch)
  );

  always @(negedge clk) if (conv_busy) busy_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // DAC write; rdl holds the read strobe low around the write
  task automatic dac_write(input logic ch, input logic rdl, input logic [DW-1:0] d);
    cs_n = 1'b0; sel_dac = 1'b1; ch_b = ch; bus_in = d; rd_n = !rdl;
    wait_clk(3);
    wr_n = 1'b0; wait_clk(3);
    wr_n = 1'b1; wait_clk(3);
    rd_n = 1'b1; cs_n = 1'b1; wait_clk(4);
  endtask

  task automatic convert(input logic ch);
    cs_n = 1'b0; sel_dac = 1'b0; ch_b = ch;
    wait_clk(2);
    wr_n = 1'b0; wait_clk(3);
    wr_n = 1'b1; wait_clk(2);
    cs_n = 1'b1; wait_clk(N + 8);
  endtask

  // strobes toggled with chip select high
  task automatic deselected(input logic sel, input logic ch);
    cs_n = 1'b1; sel_dac = sel; ch_b = ch; bus_in = 8'hEE;
    wait_clk(2);
    wr_n = 1'b0; wait_clk(3);
    wr_n = 1'b1; wait_clk(N + 6);
  endtask

  // fields: kind[28:27] ch[26] rdl[25] data[24:17] exp_a[16:9] exp_b[8:1] exp_irq[0]
  // kind 0 DAC write, 1 conversion, 2 deselected DAC write, 3 deselected conversion
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 8'h11, 8'h11, 8'h00, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'h22, 8'h11, 8'h22, 1'b1},
    {2'd1, 1'b0, 1'b0, 8'h00, 8'h11, 8'h22, 1'b0},
    {2'd0, 1'b0, 1'b0, 8'h5A, 8'h5A, 8'h22, 1'b0},
    {2'd0, 1'b1, 1'b1, 8'h99, 8'h5A, 8'h3C, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h5A, 8'h3C, 1'b0},
    {2'd0, 1'b0, 1'b1, 8'h77, 8'hC5, 8'h3C, 1'b1},
    {2'd2, 1'b1, 1'b0, 8'hEE, 8'hC5, 8'h3C, 1'b1},
    {2'd3, 1'b0, 1'b0, 8'h00, 8'hC5, 8'h3C, 1'b1}
  };

  initial begin
    int b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 dac_a", dac_a, 0);
    chk("R1 dac_b", dac_b, 0);
    chk("R1 conv_busy", conv_busy, 0);

    // table: R2 R3 R5 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      case (v[28:27])
        2'd0: dac_write(v[26], v[25], v[24:17]);
        2'd1: convert(v[26]);
        2'd2: deselected(1'b1, v[26]);
        default: deselected(1'b0, v[26]);
      endcase
      chk("R7 R8 R9 dac_a", dac_a, v[16:9]);
      chk("R7 R8 R9 dac_b", dac_b, v[8:1]);
      chk("R3 R4 R10 irq_n", irq_n, v[0]);
    end
    chk("R9 no conversion while deselected", conv_busy, 0);

    // R9 read while deselected, then R6 read
    rd_n = 1'b0; wait_clk(4);
    chk("R9 bus_oe deselected", bus_oe, 0);
    cs_n = 1'b0; wait_clk(4);
    chk("R6 bus_oe", bus_oe, 1);
    chk("R6 bus_out", bus_out, 8'hC5);
    rd_n = 1'b1; wait_clk(4);
    chk("R6 bus_oe released", bus_oe, 0);
    cs_n = 1'b1; wait_clk(2);

    // R4 busy length and interrupt; R2 channel
    b0 = busy_cnt;
    convert(1'b0);
    chk("R4 busy cycles", busy_cnt - b0, N);
    chk("R4 irq_n low after done", irq_n, 0);
    chk("R2 conv_ch", conv_ch, 0);

    // R9 read pulse while deselected keeps irq
    rd_n = 1'b0; wait_clk(3); rd_n = 1'b1; wait_clk(4);
    chk("R9 irq unchanged", irq_n, 0);
    // R5 read pulse selected clears irq
    cs_n = 1'b0; rd_n = 1'b0; wait_clk(3); rd_n = 1'b1; wait_clk(4);
    chk("R5 irq cleared by read", irq_n, 1);
    cs_n = 1'b1; wait_clk(2);

    // R11 read during conversion shows old result; R5 held read does not clear
    adc_res_b = 8'h81;
    cs_n = 1'b0; sel_dac = 1'b0; ch_b = 1'b1; wait_clk(2);
    wr_n = 1'b0; wait_clk(3);
    wr_n = 1'b1; wait_clk(2);
    rd_n = 1'b0; wait_clk(3);
    chk("R11 busy during read", conv_busy, 1);
    chk("R11 old result on bus", bus_out, 8'h3C);
    wait_clk(N + 6);
    chk("R2 R11 new result on bus", bus_out, 8'h81);
    chk("R5 held read keeps irq low", irq_n, 0);
    rd_n = 1'b1; cs_n = 1'b1; wait_clk(4);

    // R11 restart during conversion
    adc_res_a = 8'h42; adc_res_b = 8'h6E;
    b0 = busy_cnt;
    cs_n = 1'b0; sel_dac = 1'b0; ch_b = 1'b0; wait_clk(2);
    wr_n = 1'b0; wait_clk(2);
    wr_n = 1'b1; ch_b = 1'b1; wait_clk(3);
    wr_n = 1'b0; wait_clk(2);
    wr_n = 1'b1; wait_clk(2);
    cs_n = 1'b1; wait_clk(N + 10);
    chk("R11 restart busy cycles", busy_cnt - b0, N + 5);
    chk("R11 restart channel", conv_ch, 1);
    cs_n = 1'b0; rd_n = 1'b0; wait_clk(4);
    chk("R11 restart result", bus_out, 8'h6E);
    rd_n = 1'b1; cs_n = 1'b1; wait_clk(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule